// File: doc/BRIEF.md
# Carry-Select Program Counter

This block holds the instruction address of a small processor core and produces the next one on every rising clock edge. It does not use a ripple-carry adder with a forced carry-in. The address is split into slices of a few bits. The lowest slice is incremented on its own. Every upper slice computes its plus-one value at the same time, using an excess-one converter. A multiplexer then chooses, for each upper slice, between its current bits and its incremented bits. The choice depends on whether every bit below that slice is a one.

The surrounding core uses three plain control pins. A synchronous clear returns the address to zero. A jump strobe loads an externally supplied target address. A count enable lets the address advance by one. When the enable is low, the address is held. Instruction fetch, decode and branch-condition evaluation sit outside the block; the branch logic only raises the jump strobe when a jump is taken. None of the pins carries streamed data, so there is no valid/ready handshake and no back-pressure.

Top module: `pc_csel_counter`

## Requirements
- R1: The address register is cleared to 0 at the rising edge where `rst` is high. This clear wins over `jmp_ld` and `cnt_en`.
- R2: At a rising edge with `rst` low and `jmp_ld` high, `pc_addr` takes the value of `jmp_tgt`. This happens whatever the level of `cnt_en`.
- R3: At a rising edge with `rst` and `jmp_ld` low and `cnt_en` high, `pc_addr` becomes its previous value plus one.
- R4: At a rising edge with `rst`, `jmp_ld` and `cnt_en` all low, `pc_addr` keeps its value.
- R5: An increment from 1023, the all-ones address, gives 0.
- R6: With the default slice width of 5, an increment from a value whose bits [4:0] are all ones clears bits [4:0] and adds one to bits [9:5]. An example is 31 to 32.
- R7: An increment from a value whose bits [4:0] are not all ones leaves bits [9:5] unchanged. An example is 545 to 546.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous clear, active high |
| cnt_en | input | 1 | Advance the address by one |
| jmp_ld | input | 1 | Load `jmp_tgt` in place of the increment |
| jmp_tgt | input | 10 | Jump target address |
| pc_addr | output | 10 | Current instruction address |

## Verification
The counter is first run with the enable held high for more than one full cycle of the 1024 addresses. Every step is compared with address plus one modulo 1024. This run separates a correct slice carry from one that fires one step early or late at each 32-address boundary, and it covers the 1023 to 0 wrap. Next, loads are made to boundary targets: 31, 511, 1023 and 0. Each load is followed by increments, which shows whether the upper-slice select follows the new low bits. Finally, cases with several controls raised together show the order of priority: clear over load, load over increment. Periods with the enable low show that the address holds.

// File: rtl/pc_csel_pkg.sv
package pc_csel_pkg;
  localparam int unsigned PC_W_DEF    = 10;
  localparam int unsigned SLICE_W_DEF = 5;

  typedef enum logic [1:0] {
    NXT_CLEAR = 2'd0,
    NXT_LOAD  = 2'd1,
    NXT_INC   = 2'd2,
    NXT_HOLD  = 2'd3
  } nxt_src_e;
endpackage

// File: rtl/exc1_slice.sv
// Excess-one converter: x = b + 1 within the slice, each bit from a parallel AND of lower bits.
module exc1_slice #(
  parameter int unsigned W = 5
) (
  input  logic [W-1:0] b,
  output logic [W-1:0] x,
  output logic         all_ones
);
  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      if (i == 0) begin : g_lsb
        assign x[0] = ~b[0];
      end else begin : g_up
        assign x[i] = b[i] ^ (&b[i-1:0]);
      end
    end
  endgenerate

  assign all_ones = &b;
endmodule

// File: rtl/csel_incr.sv
// Carry-select incrementer built from excess-one slices.
module csel_incr #(
  parameter int unsigned PC_W    = 10,
  parameter int unsigned SLICE_W = 5
) (
  input  logic [PC_W-1:0] cur,
  output logic [PC_W-1:0] nxt
);
  localparam int unsigned NSLICE = (PC_W + SLICE_W - 1) / SLICE_W;
  localparam int unsigned LAST_W = PC_W - (NSLICE - 1) * SLICE_W;

  logic [NSLICE-1:0] slice_full;

  genvar k;
  generate
    for (k = 0; k < NSLICE; k++) begin : g_slice
      localparam int unsigned SW   = (k == NSLICE - 1) ? LAST_W : SLICE_W;
      localparam int unsigned BASE = k * SLICE_W;
      logic [SW-1:0] plain;
      logic [SW-1:0] bumped;

      assign plain = cur[BASE +: SW];

      exc1_slice #(.W(SW)) u_exc (
        .b        (plain),
        .x        (bumped),
        .all_ones (slice_full[k])
      );

      if (k == 0) begin : g_low
        assign nxt[BASE +: SW] = bumped;
      end else begin : g_high
        logic take;
        assign take = &slice_full[k-1:0];
        assign nxt[BASE +: SW] = take ? bumped : plain;
      end
    end
  endgenerate
endmodule

// File: rtl/pc_next_sel.sv
// Priority selection of the next address: clear, load, increment, hold.
module pc_next_sel
  import pc_csel_pkg::*;
#(
  parameter int unsigned PC_W = 10
) (
  input  logic            rst,
  input  logic            jmp_ld,
  input  logic            cnt_en,
  input  logic [PC_W-1:0] cur,
  input  logic [PC_W-1:0] inc_val,
  input  logic [PC_W-1:0] tgt,
  output logic [PC_W-1:0] nxt
);
  nxt_src_e src;

  always_comb begin
    if (rst)         src = NXT_CLEAR;
    else if (jmp_ld) src = NXT_LOAD;
    else if (cnt_en) src = NXT_INC;
    else             src = NXT_HOLD;
  end

  always_comb begin
    unique case (src)
      NXT_CLEAR: nxt = '0;
      NXT_LOAD:  nxt = tgt;
      NXT_INC:   nxt = inc_val;
      default:   nxt = cur;
    endcase
  end
endmodule

// File: rtl/pc_csel_counter.sv
module pc_csel_counter
  import pc_csel_pkg::*;
#(
  parameter int unsigned PC_W    = PC_W_DEF,
  parameter int unsigned SLICE_W = SLICE_W_DEF
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cnt_en,
  input  logic            jmp_ld,
  input  logic [PC_W-1:0] jmp_tgt,
  output logic [PC_W-1:0] pc_addr
);
  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] pc_inc;
  logic [PC_W-1:0] pc_d;

  csel_incr #(.PC_W(PC_W), .SLICE_W(SLICE_W)) u_incr (
    .cur (pc_q),
    .nxt (pc_inc)
  );

  pc_next_sel #(.PC_W(PC_W)) u_sel (
    .rst     (rst),
    .jmp_ld  (jmp_ld),
    .cnt_en  (cnt_en),
    .cur     (pc_q),
    .inc_val (pc_inc),
    .tgt     (jmp_tgt),
    .nxt     (pc_d)
  );

  always_ff @(posedge clk) begin
    pc_q <= pc_d;
  end

  assign pc_addr = pc_q;
endmodule

// File: rtl/pc_csel_counter_chk.sv
module pc_csel_counter_chk #(
  parameter int unsigned PC_W    = 10,
  parameter int unsigned SLICE_W = 5
) (
  input logic            clk,
  input logic            rst,
  input logic            cnt_en,
  input logic            jmp_ld,
  input logic [PC_W-1:0] jmp_tgt,
  input logic [PC_W-1:0] pc_addr
);
  logic seen_rst = 1'b0;
  always_ff @(posedge clk) begin
    if (rst) seen_rst <= 1'b1;
  end

  logic adv;
  assign adv = !rst && !jmp_ld && cnt_en;

  // R1
  clear_to_zero_chk: assert property (@(posedge clk) disable iff (!seen_rst)
    rst |=> (pc_addr == '0));

  // R2
  jump_load_chk: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    jmp_ld |=> (pc_addr == $past(jmp_tgt)));

  // R3
  step_one_chk: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    adv |=> (pc_addr == PC_W'($past(pc_addr) + 1'b1)));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    (!jmp_ld && !cnt_en) |=> $stable(pc_addr));

  // R5
  wrap_chk: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    (adv && (&pc_addr)) |=> (pc_addr == '0));

  // R6
  slice_carry_chk: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    (adv && (&pc_addr[SLICE_W-1:0])) |=>
      (pc_addr[SLICE_W-1:0] == '0) &&
      (pc_addr[PC_W-1:SLICE_W] == (PC_W-SLICE_W)'($past(pc_addr[PC_W-1:SLICE_W]) + 1'b1)));

  // R7
  upper_keep_chk: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    (adv && !(&pc_addr[SLICE_W-1:0])) |=> $stable(pc_addr[PC_W-1:SLICE_W]));
endmodule

bind pc_csel_counter pc_csel_counter_chk #(.PC_W(PC_W), .SLICE_W(SLICE_W)) u_chk (.*);

// File: tb/sim_pc_csel_counter.sv
`timescale 1ns/1ps
module sim_pc_csel_counter;
  localparam int PC_W = 10;
  localparam int NADDR = 1 << PC_W;

  logic            clk = 1'b0;
  logic            rst = 1'b0;
  logic            cnt_en = 1'b0;
  logic            jmp_ld = 1'b0;
  logic [PC_W-1:0] jmp_tgt = '0;
  logic [PC_W-1:0] pc_addr;

  int n_chk  = 0;
  int n_fail = 0;
  int expv   = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  pc_csel_counter u0 (
    .clk     (clk),
    .rst     (rst),
    .cnt_en  (cnt_en),
    .jmp_ld  (jmp_ld),
    .jmp_tgt (jmp_tgt),
    .pc_addr (pc_addr)
  );

  task automatic check(input string req, input int exp_v);
    n_chk++;
    if (int'(pc_addr) != exp_v) begin
      n_fail++;
      $display("FAIL %s: pc_addr=%0d expected=%0d", req, pc_addr, exp_v);
    end
  endtask

  // One cycle: drive at the falling edge, update the model at the rising edge, check at the next falling edge.
  task automatic cyc(input bit r, input bit ld, input int tgt, input bit en, input string req);
    rst = r; jmp_ld = ld; jmp_tgt = PC_W'(tgt); cnt_en = en;
    @(posedge clk);
    if (r)       expv = 0;
    else if (ld) expv = tgt;
    else if (en) expv = (expv + 1) % NADDR;
    @(negedge clk);
    check(req, expv);
  endtask

  initial begin
    @(negedge clk);
    // R1 reset state
    cyc(1, 0, 0, 0, "R1");
    cyc(1, 1, 700, 1, "R1");
    // R3 R5 R6 R7 full sweep with enable high
    for (int i = 0; i < NADDR + 40; i++) begin
      int prev = expv;
      string tag;
      if (prev == NADDR - 1)       tag = "R5";
      else if ((prev % 32) == 31)  tag = "R6";
      else                         tag = "R7";
      cyc(0, 0, 0, 1, tag);
    end
    // R4 hold
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, "R4");
    // R2 loads to boundary targets, then increments
    cyc(0, 1, 31, 0, "R2");
    cyc(0, 0, 0, 1, "R6");
    cyc(0, 1, 511, 1, "R2");
    cyc(0, 0, 0, 1, "R6");
    cyc(0, 1, 1023, 1, "R2");
    cyc(0, 0, 0, 1, "R5");
    cyc(0, 1, 545, 0, "R2");
    cyc(0, 0, 0, 1, "R7");
    cyc(0, 0, 0, 0, "R4");
    cyc(0, 1, 0, 1, "R2");
    cyc(0, 0, 0, 1, "R3");
    // R1 clear wins over load
    cyc(0, 1, 300, 0, "R2");
    cyc(1, 1, 900, 1, "R1");
    cyc(0, 0, 0, 1, "R3");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule